// File: doc/BRIEF.md
# Triggered Serial Pattern Generator

The block plays a fixed bit pattern out on one serial line, one bit per clock, each time a single-cycle start request arrives. The pattern and its length are elaboration-time parameters (40 bits by default). The first bit sent is bit 0, and bits follow in rising index order. A run flag is set by the start request. A position counter walks through the pattern while the flag is set. The flag drops once the final index has been driven, unless a new start request arrives in that same cycle.

When the block is idle, the serial line carries pattern bit 0 and the counter is held at zero. To produce a burst of ones framed by zeros, make bit 0 of the pattern a zero and set the bits after it to one.

A completion output is high in exactly the cycle in which the last pattern bit is on the line. The counter is ceil(log2(length)) bits wide. It returns to zero after the final index, so it never leaves the pattern's range. The output frequency follows the input clock.

Top module: `serial_pattern_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the serial output equals pattern bit 0 and the completion output is low.
- R2: A start request sampled at a clock edge makes the serial output carry pattern bit i in the (i+1)-th cycle after that edge, for i from 0 to length-1, with bit 0 sent first.
- R3: The completion output is high only in the cycle that carries pattern bit length-1, so it rises exactly once per sequence.
- R4: After the last bit, if no start request is present, the block goes idle. The serial output then stays at pattern bit 0 and completion stays low until the next start.
- R5: A start request sampled while a sequence is running, other than in its last cycle, has no effect: the sequence continues with no restart.
- R6: A start request sampled in the cycle where completion is high wins over the stop. Pattern bit 0 follows directly, with no idle cycle in between.
- R7: Holding start high continuously repeats the pattern with a period of exactly length cycles, with one completion pulse per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start request, sampled at each rising edge |
| done_o | output | 1 | High while the final pattern bit is on the line |
| serial_o | output | 1 | Serial pattern bit |

## Verification
The bench uses an asymmetric pattern. A design that sends the pattern most-significant bit first, or that is off by one cycle, therefore mismatches on many bits. A start request placed mid-sequence checks R5: a design that restarts would replay bit 0 early. A start request placed on the completion cycle checks R6: a design that lets the stop win would insert an idle cycle. Long runs with start held high check R7. The bench also counts completion rises against the number of sequences. A counter that runs past the last index, or a completion signal that is not tied to that index, produces extra or missing pulses or out-of-range output bits.

// File: rtl/spg_pkg.sv
package spg_pkg;

  // Width of a position index for a pattern of the given length.
  function automatic int pos_width(input int len);
    return (len > 1) ? $clog2(len) : 1;
  endfunction

endpackage

// File: rtl/spg_run_ctrl.sv
module spg_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic last_i,
  output logic run_o
);

  logic run_q;
  logic run_nx;

  // Start has priority over the stop at the last index.
  always_comb begin
    run_nx = run_q;
    if (start_i)     run_nx = 1'b1;
    else if (last_i) run_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_nx;
  end

  assign run_o = run_q;

  a_r6_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> run_o);

  a_r4_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (last_i && !start_i) |=> !run_o);

endmodule

// File: rtl/spg_pos_counter.sv
module spg_pos_counter #(
  parameter int LEN = 40,
  parameter int W   = spg_pkg::pos_width(LEN)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  output logic [W-1:0] pos_o,
  output logic         last_o
);

  localparam logic [W-1:0] LAST_POS = W'(LEN - 1);

  logic [W-1:0] pos_q;
  logic [W-1:0] pos_nx;
  logic         pos_en;
  logic         at_last;

  assign at_last = (pos_q == LAST_POS);

  always_comb begin
    if (!run_i)       pos_nx = '0;
    else if (at_last) pos_nx = '0;
    else              pos_nx = pos_q + W'(1);
  end

  // Only load when running, or to clear a non-zero count.
  assign pos_en = run_i || (pos_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (pos_en) pos_q <= pos_nx;
  end

  assign pos_o  = pos_q;
  assign last_o = at_last;

  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (pos_o == '0));

  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !last_o) |=> (pos_o == $past(pos_o) + W'(1)));

  a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && last_o) |=> (pos_o == '0));

  a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pos_o <= LAST_POS);

endmodule

// File: rtl/spg_bit_select.sv
module spg_bit_select #(
  parameter int             LEN     = 40,
  parameter int             W       = spg_pkg::pos_width(LEN),
  parameter logic [LEN-1:0] PATTERN = '0
) (
  input  logic [W-1:0] pos_i,
  output logic         bit_o
);

  localparam int PADW = 1 << W;

  logic [PADW-1:0] padded;

  // Pad to a full power-of-two table so every index is in range.
  generate
    if (PADW == LEN) begin : g_exact
      assign padded = PATTERN;
    end else begin : g_pad
      assign padded = {{(PADW - LEN){1'b0}}, PATTERN};
    end
  endgenerate

  assign bit_o = padded[pos_i];

endmodule

// File: rtl/serial_pattern_gen.sv
module serial_pattern_gen #(
  parameter int             PAT_LEN = 40,
  parameter logic [PAT_LEN-1:0] PATTERN = {{(PAT_LEN-1){1'b1}}, 1'b0}
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic done_o,
  output logic serial_o
);

  localparam int CNT_W = spg_pkg::pos_width(PAT_LEN);

  logic             run;
  logic             last;
  logic [CNT_W-1:0] pos;

  spg_run_ctrl u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .last_i  (last),
    .run_o   (run)
  );

  spg_pos_counter #(.LEN(PAT_LEN), .W(CNT_W)) u_pos (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .pos_o  (pos),
    .last_o (last)
  );

  spg_bit_select #(.LEN(PAT_LEN), .W(CNT_W), .PATTERN(PATTERN)) u_sel (
    .pos_i (pos),
    .bit_o (serial_o)
  );

  assign done_o = last;

  generate
    if (PAT_LEN > 1) begin : g_chk
      a_r3_done_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> run);
      a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o || $past(start_i));
    end
  endgenerate

endmodule

// File: tb/serial_pattern_gen_bench.sv
module serial_pattern_gen_bench;

  localparam int             LEN = 40;
  localparam logic [LEN-1:0] PAT = 40'hC3_5A_F0_96_1E;

  logic clk;
  logic rst_n;
  logic start_i;
  logic done_o;
  logic serial_o;

  int n_cmp;
  int n_bad;
  bit finished;

  // Reference state, kept from the requirements.
  bit m_run;
  int m_idx;
  bit m_done_prev;
  int exp_rises;
  int got_rises;
  bit got_done_prev;
  string cur_tag;

  bit [1:0] q_val[$];
  string    q_tag[$];

  serial_pattern_gen #(.PAT_LEN(LEN), .PATTERN(PAT)) u_serial_pattern_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .done_o   (done_o),
    .serial_o (serial_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input bit [1:0] act, input bit [1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s done,serial actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus plus the expected result after the edge.
  task automatic step(input bit s);
    bit last;
    bit nd;
    @(negedge clk);
    start_i = s;
    last = m_run && (m_idx == LEN - 1);
    if (!m_run || last) m_idx = 0;
    else                m_idx = m_idx + 1;
    m_run = s ? 1'b1 : (last ? 1'b0 : m_run);
    nd = m_run && (m_idx == LEN - 1);
    if (nd && !m_done_prev) exp_rises++;
    m_done_prev = nd;
    q_val.push_back({nd, PAT[m_idx]});
    q_tag.push_back(cur_tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start_i = 1'b0;
    m_run = 1'b0;
    m_idx = 0;
    m_done_prev = 1'b0;
    #1;
    check("R1 in reset", {done_o, serial_o}, {1'b0, PAT[0]});
    @(negedge clk);
    check("R1 held reset", {done_o, serial_o}, {1'b0, PAT[0]});
    rst_n = 1'b1;
  endtask

  // Monitor: compares after each edge, before the next drive.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && done_o && !got_done_prev) got_rises++;
      got_done_prev = rst_n && done_o;
      if (q_val.size() > 0) begin
        check(q_tag.pop_front(), {done_o, serial_o}, q_val.pop_front());
      end
    end
  end

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    cur_tag = "R1";
    do_reset();
    cur_tag = "R1 idle after reset";
    repeat (3) step(1'b0);

    // R2, R3, R4: one plain sequence, then idle.
    cur_tag = "R2 R3 single run";
    step(1'b1);
    repeat (LEN) step(1'b0);
    cur_tag = "R4 idle after last";
    repeat (6) step(1'b0);

    // R5: start requests in mid-sequence are ignored.
    cur_tag = "R5 start while running";
    step(1'b1);
    repeat (10) step(1'b0);
    step(1'b1);
    repeat (7) step(1'b0);
    step(1'b1);
    while (m_run) step(1'b0);
    repeat (3) step(1'b0);

    // R6: start on the completion cycle gives back-to-back sequences.
    cur_tag = "R6 start on last";
    step(1'b1);
    while (!(m_run && m_idx == LEN - 1)) step(1'b0);
    step(1'b1);
    while (!(m_run && m_idx == LEN - 1)) step(1'b0);
    step(1'b1);
    while (m_run) step(1'b0);
    repeat (2) step(1'b0);

    // R7: start held high repeats the pattern.
    cur_tag = "R7 start held";
    repeat (3 * LEN) step(1'b1);
    cur_tag = "R4 stop after held";
    while (m_run) step(1'b0);
    repeat (2) step(1'b0);

    // R1: reset in the middle of a sequence.
    cur_tag = "R2 before reset";
    step(1'b1);
    repeat (12) step(1'b0);
    @(posedge clk);
    #3;
    do_reset();
    cur_tag = "R1 idle after mid reset";
    repeat (3) step(1'b0);
    cur_tag = "R2 after mid reset";
    step(1'b1);
    while (m_run) step(1'b0);
    step(1'b0);

    @(posedge clk);
    #3;
    n_cmp++;
    if (got_rises != exp_rises) begin
      n_bad++;
      $display("FAIL R3 completion rises actual=%0d expected=%0d", got_rises, exp_rises);
    end
    finish_up();
  end

endmodule